// File: doc/BRIEF.md
# Floating-Point Store Exception Status and Trap Arbiter

This block closes out a floating-point register-to-memory move. After the conversion datapath has turned an extended-precision value into the destination format, it passes its raw invalid, overflow, underflow and inexact flags here. The block also takes the destination format, the exponent and mantissa fields of the source value, the current status register and the trap-enable byte of the control register. It rebuilds the per-instruction exception byte according to the destination format class. It merges that byte into the sticky accrued-exception bits, and arbitrates among the enabled exceptions to pick a single trap vector.

The update arrives as a valid/ready transfer. `upd_ready` is held high at all times, so the block never applies back-pressure: every cycle with `upd_valid` high is one accepted update. Its result appears on the following cycle with `res_valid` high for exactly one cycle, and there is no output back-pressure. The status result, trap request, vector and commit-suppress signal are plain signals qualified by `res_valid`. When a trap fires, `suppress_commit` tells the address unit to drop the pending address-register increment or decrement.

Status layout used by the block: exception byte in bits 15:8 (15 branch-unordered, 14 signalling NaN, 13 operand error, 12 overflow, 11 underflow, 10 divide-by-zero, 9 inexact-2, 8 inexact-1). Accrued bits occupy 7:3 (7 invalid-op, 6 overflow, 5 underflow, 4 divide-by-zero, 3 inexact). Bits 31:16 and 2:0 are held unchanged.

Top module: `fpu_exc_arbiter`

## Requirements
- R1: After reset, `res_valid`, `trap_req` and `suppress_commit` are low and `res_status` is zero.
- R2: Each accepted update clears all eight exception bits first; branch-unordered (15), divide-by-zero (10) and inexact-1 (8) are always zero in the result.
- R3: For integer destinations (format codes byte=6, word=4, long=0), only signalling-NaN (14), operand error (13, from raw invalid) and inexact-2 (9, from raw inexact) may be set; overflow and underflow bits stay zero whatever the raw flags say.
- R4: For float destinations (single=1, double=5, extended=2), only signalling-NaN (14), overflow (12), underflow (11) and inexact-2 (9) may be set from their raw flags; operand error stays zero even with raw invalid high.
- R5: For packed destinations (codes 3 and 7), no exception bit is set and the accrued bits are unchanged.
- R6: The NaN indication is true exactly when all 15 exponent bits are ones and the 64-bit mantissa is nonzero, and it drives bit 14 for integer and float classes.
- R7: Accrued invalid-op (7) ORs in bits 15, 14 and 13; accrued overflow (6) ORs in bit 12; accrued divide-by-zero (4) ORs in bit 10.
- R8: Accrued underflow (5) ORs in the AND of bits 11 and 9; accrued inexact (3) ORs in bits 9, 8 and 12.
- R9: Status bits 31:16 and 2:0 in the result equal those of `stat_in` at acceptance.
- R10: A trap is requested when the new exception byte AND `trap_enable` is nonzero; the vector is `VEC_TABLE[i]`, where i is 0 for bit 15 up to 7 for bit 8, taken from the highest set bit of that AND.
- R11: `trap_req` and `suppress_commit` are high only in a `res_valid` cycle, both high exactly when a trap is requested.
- R12: `upd_ready` is always high and each update produces `res_valid` on the next cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Update transfer valid |
| upd_ready | output | 1 | Always high; no back-pressure |
| upd_fmt | input | 3 | Destination format code |
| src_exp | input | 15 | Source biased exponent (sign excluded) |
| src_mant | input | 64 | Source mantissa |
| raw_invalid | input | 1 | Conversion invalid flag |
| raw_overflow | input | 1 | Conversion overflow flag |
| raw_underflow | input | 1 | Conversion underflow flag |
| raw_inexact | input | 1 | Conversion inexact flag |
| stat_in | input | 32 | Current status register |
| trap_enable | input | 8 | Enable byte (bit 7 pairs with status bit 15) |
| res_valid | output | 1 | Result valid, one cycle per update |
| res_status | output | 32 | Updated status register |
| trap_req | output | 1 | Trap request pulse |
| trap_vec | output | 8 | Selected trap vector |
| suppress_commit | output | 1 | Drop address-register commit |

## Verification
The bench runs the format boundary: raw overflow, underflow and invalid are fed on every class. A design that mis-decodes a format code leaks overflow into an integer store or operand error into a float store. The NaN detector is probed with an all-ones exponent and a zero mantissa, and with an exponent one short of all ones; a detector that ignores either field flags infinities or finite values. Underflow without inexact is driven to catch an accrued underflow that forgot the AND. Overflow alone is driven to catch accrued inexact missing its overflow term. Several enable bits are set at once, so a priority search running the wrong way returns the vector of the lowest-priority exception.

// File: rtl/fpu_exc_pkg.sv
package fpu_exc_pkg;

  typedef enum logic [2:0] {
    FMT_LONG   = 3'd0,
    FMT_SINGLE = 3'd1,
    FMT_EXT    = 3'd2,
    FMT_PACKS  = 3'd3,
    FMT_WORD   = 3'd4,
    FMT_DOUBLE = 3'd5,
    FMT_BYTE   = 3'd6,
    FMT_PACKD  = 3'd7
  } dst_fmt_e;

  typedef enum logic [1:0] {
    CLS_INT  = 2'd0,
    CLS_FLT  = 2'd1,
    CLS_NONE = 2'd2
  } fmt_class_e;

  // Field order mirrors trap priority: first member is highest priority.
  typedef struct packed {
    logic bsun;
    logic snan;
    logic operr;
    logic ovfl;
    logic unfl;
    logic dz;
    logic inex2;
    logic inex1;
  } exc_byte_t;

  typedef struct packed {
    logic iop;
    logic ovfl;
    logic unfl;
    logic dz;
    logic inex;
  } acc_bits_t;

  localparam int EXC_LSB = 8;
  localparam int ACC_LSB = 3;

  function automatic fmt_class_e classify(input logic [2:0] code);
    case (code)
      FMT_BYTE, FMT_WORD, FMT_LONG:    classify = CLS_INT;
      FMT_SINGLE, FMT_DOUBLE, FMT_EXT: classify = CLS_FLT;
      default:                         classify = CLS_NONE;
    endcase
  endfunction

endpackage

// File: rtl/fpu_exc_nan_det.sv
module fpu_exc_nan_det #(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic [EXP_W-1:0] exp_field,
  input  logic [MAN_W-1:0] man_field,
  output logic             is_nan
);
  logic exp_max;
  logic man_nz;

  assign exp_max = &exp_field;
  assign man_nz  = |man_field;
  assign is_nan  = exp_max & man_nz;
endmodule

// File: rtl/fpu_exc_status_upd.sv
module fpu_exc_status_upd
  import fpu_exc_pkg::*;
(
  input  logic [2:0] fmt,
  input  logic       nan_src,
  input  logic       f_invalid,
  input  logic       f_overflow,
  input  logic       f_underflow,
  input  logic       f_inexact,
  input  acc_bits_t  acc_old,
  output exc_byte_t  exc_new,
  output acc_bits_t  acc_new
);
  fmt_class_e cls;

  assign cls = classify(fmt);

  // Exception byte: start from all-clear, then set per class.
  always_comb begin
    exc_new = '0;
    case (cls)
      CLS_INT: begin
        exc_new.snan  = nan_src;
        exc_new.operr = f_invalid;
        exc_new.inex2 = f_inexact;
      end
      CLS_FLT: begin
        exc_new.snan  = nan_src;
        exc_new.ovfl  = f_overflow;
        exc_new.unfl  = f_underflow;
        exc_new.inex2 = f_inexact;
      end
      default: exc_new = '0;
    endcase
  end

  // Sticky accrual with the irregular underflow and inexact terms.
  always_comb begin
    acc_new.iop  = acc_old.iop  | exc_new.bsun | exc_new.snan | exc_new.operr;
    acc_new.ovfl = acc_old.ovfl | exc_new.ovfl;
    acc_new.unfl = acc_old.unfl | (exc_new.unfl & exc_new.inex2);
    acc_new.dz   = acc_old.dz   | exc_new.dz;
    acc_new.inex = acc_old.inex | exc_new.inex1 | exc_new.inex2 | exc_new.ovfl;
  end
endmodule

// File: rtl/fpu_exc_prio.sv
module fpu_exc_prio #(
  parameter int N     = 8,
  parameter int VEC_W = 8,
  parameter logic [N-1:0][VEC_W-1:0] TABLE = '0
) (
  input  logic [N-1:0]     pending,
  input  logic [N-1:0]     enable,
  output logic             hit,
  output logic [VEC_W-1:0] vec
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]     armed;
  logic [IDX_W-1:0] sel;

  assign armed = pending & enable;
  assign hit   = |armed;

  // Highest bit wins; bit N-1 maps to table index 0.
  always_comb begin
    sel = '0;
    for (int b = 0; b < N; b++) begin
      if (armed[b]) sel = IDX_W'(N - 1 - b);
    end
  end

  assign vec = TABLE[sel];
endmodule

// File: rtl/fpu_exc_arbiter.sv
module fpu_exc_arbiter
  import fpu_exc_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64,
  parameter int VEC_W = 8,
  parameter logic [7:0][VEC_W-1:0] VEC_TABLE = {
    VEC_W'(49), VEC_W'(49), VEC_W'(50), VEC_W'(51),
    VEC_W'(53), VEC_W'(52), VEC_W'(54), VEC_W'(48)
  }
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_valid,
  output logic             upd_ready,
  input  logic [2:0]       upd_fmt,
  input  logic [EXP_W-1:0] src_exp,
  input  logic [MAN_W-1:0] src_mant,
  input  logic             raw_invalid,
  input  logic             raw_overflow,
  input  logic             raw_underflow,
  input  logic             raw_inexact,
  input  logic [31:0]      stat_in,
  input  logic [7:0]       trap_enable,
  output logic             res_valid,
  output logic [31:0]      res_status,
  output logic             trap_req,
  output logic [VEC_W-1:0] trap_vec,
  output logic             suppress_commit
);
  localparam int EXC_N = $bits(exc_byte_t);
  localparam int ACC_N = $bits(acc_bits_t);

  logic             nan_src;
  exc_byte_t        exc_new;
  acc_bits_t        acc_old;
  acc_bits_t        acc_new;
  logic             hit;
  logic [VEC_W-1:0] vec;
  logic [31:0]      stat_next;

  assign upd_ready = 1'b1;
  assign acc_old   = stat_in[ACC_LSB +: ACC_N];

  fpu_exc_nan_det #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_nan (
    .exp_field (src_exp),
    .man_field (src_mant),
    .is_nan    (nan_src)
  );

  fpu_exc_status_upd u_upd (
    .fmt         (upd_fmt),
    .nan_src     (nan_src),
    .f_invalid   (raw_invalid),
    .f_overflow  (raw_overflow),
    .f_underflow (raw_underflow),
    .f_inexact   (raw_inexact),
    .acc_old     (acc_old),
    .exc_new     (exc_new),
    .acc_new     (acc_new)
  );

  fpu_exc_prio #(.N(EXC_N), .VEC_W(VEC_W), .TABLE(VEC_TABLE)) u_prio (
    .pending (exc_new),
    .enable  (trap_enable),
    .hit     (hit),
    .vec     (vec)
  );

  always_comb begin
    stat_next = stat_in;
    stat_next[EXC_LSB +: EXC_N] = exc_new;
    stat_next[ACC_LSB +: ACC_N] = acc_new;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid       <= 1'b0;
      res_status      <= '0;
      trap_req        <= 1'b0;
      trap_vec        <= '0;
      suppress_commit <= 1'b0;
    end else begin
      res_valid       <= upd_valid;
      trap_req        <= upd_valid & hit;
      suppress_commit <= upd_valid & hit;
      if (upd_valid) res_status <= stat_next;
      if (upd_valid & hit) trap_vec <= vec;
    end
  end

  // Assertions
  a_r11_trap_only_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> res_valid);

  a_r11_suppress_only_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    suppress_commit |-> res_valid);

  a_r10_trap_is_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && trap_req) |-> ((res_status[15:8] & $past(trap_enable)) != 8'h00));

  a_r10_no_trap_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !trap_req) |-> ((res_status[15:8] & $past(trap_enable)) == 8'h00));

  a_r9_upper_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_status[31:16] == $past(stat_in[31:16]) &&
                   res_status[2:0]  == $past(stat_in[2:0])));

  a_r7_accrued_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((res_status[7:3] & $past(stat_in[7:3])) == $past(stat_in[7:3])));

  a_r2_fixed_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (!res_status[15] && !res_status[10] && !res_status[8]));

  a_r12_one_result_per_update: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(upd_valid));
endmodule

// File: tb/fpu_exc_arbiter_tb_top.sv
module fpu_exc_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_valid = 1'b0;
  logic        upd_ready;
  logic [2:0]  upd_fmt = '0;
  logic [14:0] src_exp = '0;
  logic [63:0] src_mant = '0;
  logic        raw_invalid = 1'b0, raw_overflow = 1'b0, raw_underflow = 1'b0, raw_inexact = 1'b0;
  logic [31:0] stat_in = '0;
  logic [7:0]  trap_enable = '0;
  logic        res_valid;
  logic [31:0] res_status;
  logic        trap_req;
  logic [7:0]  trap_vec;
  logic        suppress_commit;

  int checks = 0;
  int failures = 0;

  // expected state for the next result cycle
  bit          exp_valid = 0;
  logic [31:0] exp_stat;
  bit          exp_trap;
  logic [7:0]  exp_vec;
  int          exp_fmt;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpu_exc_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_ready(upd_ready),
    .upd_fmt(upd_fmt), .src_exp(src_exp), .src_mant(src_mant),
    .raw_invalid(raw_invalid), .raw_overflow(raw_overflow),
    .raw_underflow(raw_underflow), .raw_inexact(raw_inexact),
    .stat_in(stat_in), .trap_enable(trap_enable),
    .res_valid(res_valid), .res_status(res_status), .trap_req(trap_req),
    .trap_vec(trap_vec), .suppress_commit(suppress_commit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h time=%0t", req, act, expv, $time);
    end
  endtask

  function automatic int vec_of(input int idx);
    case (idx)
      0: return 48; 1: return 54; 2: return 52; 3: return 53;
      4: return 51; 5: return 50; default: return 49;
    endcase
  endfunction

  // Behavioural reference from the requirements
  task automatic model();
    bit nan, is_int, is_flt;
    bit bsun, sn, oe, ov, un, dz, i2, i1;
    logic [31:0] s;
    logic [7:0] exc, armed;
    nan = (src_exp == 15'h7FFF) && (src_mant != 0);                       // R6
    is_int = (upd_fmt == 6) || (upd_fmt == 4) || (upd_fmt == 0);           // R3
    is_flt = (upd_fmt == 1) || (upd_fmt == 5) || (upd_fmt == 2);           // R4
    bsun = 0; dz = 0; i1 = 0; sn = 0; oe = 0; ov = 0; un = 0; i2 = 0;      // R2
    if (is_int) begin sn = nan; oe = raw_invalid; i2 = raw_inexact; end
    if (is_flt) begin sn = nan; ov = raw_overflow; un = raw_underflow; i2 = raw_inexact; end
    exc = {bsun, sn, oe, ov, un, dz, i2, i1};
    s = stat_in;
    s[15:8] = exc;
    s[7] = stat_in[7] | bsun | sn | oe;                                    // R7
    s[6] = stat_in[6] | ov;
    s[5] = stat_in[5] | (un & i2);                                         // R8
    s[4] = stat_in[4] | dz;
    s[3] = stat_in[3] | i1 | i2 | ov;
    exp_stat = s;
    armed = exc & trap_enable;                                             // R10
    exp_trap = (armed != 0);
    exp_vec = 8'h00;
    for (int i = 0; i < 8; i++) begin
      if (armed[7-i]) begin exp_vec = 8'(vec_of(i)); break; end
    end
    exp_fmt = int'(upd_fmt);
  endtask

  task automatic compare();
    string cls;
    chk("R12 res_valid timing", {31'd0, res_valid}, {31'd0, exp_valid});
    chk("R12 upd_ready high", {31'd0, upd_ready}, 32'd1);
    if (exp_valid) begin
      cls = (exp_fmt == 0 || exp_fmt == 4 || exp_fmt == 6) ? "R3 integer exc byte" :
            (exp_fmt == 3 || exp_fmt == 7) ? "R5 packed exc byte" : "R4 float exc byte";
      chk(cls, {24'd0, res_status[15:8]}, {24'd0, exp_stat[15:8]});
      chk("R6 nan bit", {31'd0, res_status[14]}, {31'd0, exp_stat[14]});
      chk("R2 bsun/dz/inex1 clear", {29'd0, res_status[15], res_status[10], res_status[8]}, 32'd0);
      chk("R7 accrued iop/ovfl/dz", {29'd0, res_status[7], res_status[6], res_status[4]},
          {29'd0, exp_stat[7], exp_stat[6], exp_stat[4]});
      chk("R8 accrued unfl/inex", {30'd0, res_status[5], res_status[3]},
          {30'd0, exp_stat[5], exp_stat[3]});
      chk("R9 passthrough bits", {res_status[31:16], 13'd0, res_status[2:0]},
          {exp_stat[31:16], 13'd0, exp_stat[2:0]});
      chk("R10 trap request", {31'd0, trap_req}, {31'd0, exp_trap});
      if (exp_trap) chk("R10 trap vector", {24'd0, trap_vec}, {24'd0, exp_vec});
      chk("R11 suppress commit", {31'd0, suppress_commit}, {31'd0, exp_trap});
    end else begin
      chk("R11 no trap when idle", {31'd0, trap_req}, 32'd0);
      chk("R11 no suppress when idle", {31'd0, suppress_commit}, 32'd0);
    end
  endtask

  // One cycle: at negedge compare previous, then drive new
  task automatic step(input bit v, input int f, input logic [14:0] e, input logic [63:0] m,
                      input bit inv, input bit ovf, input bit unf, input bit inx,
                      input logic [31:0] st, input logic [7:0] en);
    @(negedge clk);
    compare();
    upd_valid = v; upd_fmt = 3'(f); src_exp = e; src_mant = m;
    raw_invalid = inv; raw_overflow = ovf; raw_underflow = unf; raw_inexact = inx;
    stat_in = st; trap_enable = en;
    if (v) model();
    exp_valid = v;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 reset res_valid", {31'd0, res_valid}, 32'd0);
    chk("R1 reset trap_req", {31'd0, trap_req}, 32'd0);
    chk("R1 reset suppress", {31'd0, suppress_commit}, 32'd0);
    chk("R1 reset status", res_status, 32'd0);
    rst_n = 1'b1;
    // integer store with all raw flags: R3
    step(1, 6, 15'h1234, 64'h1, 1, 1, 1, 1, 32'h0000_0000, 8'h00);
    // float store with all raw flags: R4
    step(1, 1, 15'h1234, 64'h1, 1, 1, 1, 1, 32'h0000_0000, 8'h00);
    // packed: R5
    step(1, 3, 15'h7FFF, 64'h5, 1, 1, 1, 1, 32'hA5A5_00FF, 8'hFF);
    step(1, 7, 15'h7FFF, 64'h5, 1, 1, 1, 1, 32'h0000_0000, 8'hFF);
    // R6 NaN boundaries
    step(1, 0, 15'h7FFF, 64'h0, 0, 0, 0, 0, 32'h0, 8'h40);
    step(1, 0, 15'h7FFE, 64'hFFFF, 0, 0, 0, 0, 32'h0, 8'h40);
    step(1, 2, 15'h7FFF, 64'h8000_0000_0000_0000, 0, 0, 0, 0, 32'h0, 8'h40);
    // R8 underflow without inexact, overflow alone
    step(1, 5, 15'h0, 64'h0, 0, 0, 1, 0, 32'h0, 8'h00);
    step(1, 5, 15'h0, 64'h0, 0, 1, 0, 0, 32'h0, 8'h00);
    step(1, 5, 15'h0, 64'h0, 0, 0, 1, 1, 32'h0, 8'h00);
    // R10 priority with many enables
    step(1, 2, 15'h7FFF, 64'h3, 0, 1, 1, 1, 32'h0, 8'hFF);
    step(1, 2, 15'h0, 64'h3, 0, 1, 1, 1, 32'h0, 8'h0F);
    step(1, 4, 15'h0, 64'h3, 1, 0, 0, 1, 32'h0, 8'h22);
    step(1, 1, 15'h0, 64'h3, 0, 0, 1, 1, 32'h0, 8'h06);
    // idle gap then back-to-back traps: R11, R12
    step(0, 0, 15'h0, 64'h0, 1, 1, 1, 1, 32'h0, 8'hFF);
    step(1, 6, 15'h0, 64'h0, 1, 0, 0, 0, 32'hFFFF_0007, 8'h20);
    step(1, 6, 15'h0, 64'h0, 1, 0, 0, 0, 32'h1234_0005, 8'h20);
    // pseudo-random sweep
    for (int n = 0; n < 400; n++) begin
      logic [14:0] e;
      logic [63:0] m;
      int pick;
      pick = $urandom_range(0, 3);
      e = (pick == 0) ? 15'h7FFF : (pick == 1) ? 15'h7FFE : 15'($urandom);
      m = ($urandom_range(0, 3) == 0) ? 64'h0 : {32'($urandom), 32'($urandom)};
      step($urandom_range(0, 4) != 0, $urandom_range(0, 7), e, m,
           1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           32'($urandom), 8'($urandom));
    end
    step(0, 0, 15'h0, 64'h0, 0, 0, 0, 0, 32'h0, 8'h0);
    step(0, 0, 15'h0, 64'h0, 0, 0, 0, 0, 32'h0, 8'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule